// File: doc/BRIEF.md
# Unified Input Buffer Slot Manager

This block runs one input port of a network-on-chip router. It does not give each virtual channel its own FIFO. It keeps a single shared pool of flit slots. Each arriving flit goes into a free slot. A slot is free when the two type bits it holds read 00, so no separate occupancy flag exists. A header is offered to route computation in the same cycle that it is stored. The flits of a packet wait in a pending record until the virtual channel allocator grants a channel. After the grant, the packet's slot list moves to that channel's entry in a control table, and later flits of the packet are appended to it directly.

The switch-allocation side reads by virtual channel. The table gives the slot that holds that channel's oldest flit, so flits leave in the order they arrived. Reading a flit clears its slot's type bits, which frees the slot. Reading a tail also frees the channel entry. The per-slot free vector goes upstream as credit.

Flit type codes in bits [1:0]: 01 header, 10 body, 11 tail, 00 empty. A packet is one header, two bodies and a tail (PKT_LEN = 4). Defaults: 16 slots, 128-bit flits, 4 virtual channels.

Top module: `ubs_slot_mgr`

## Requirements
- R1: After reset, all slots are free (`credit_o` all ones), `in_ready_o` is high and no `vc_busy_o` bit is set.
- R2: A stored flit goes into the lowest-indexed slot whose type bits are 00. That slot's `credit_o` bit clears at the clock edge that stores the flit. A slot freed by a read in the same cycle is not yet a candidate.
- R3: When a header (type 01) is accepted, `hdr_valid_o` is high in the same cycle. `hdr_slot_o` gives the slot chosen for it and `hdr_flit_o` equals the input flit. `hdr_valid_o` stays low for all other flits.
- R4: An accepted flit whose type is 00 is discarded. A body or tail that arrives while no packet is open is also discarded. Neither changes any slot.
- R5: `in_ready_o` is low when no slot is free. It is also low when a header is offered while an earlier packet still waits for a channel grant.
- R6: A grant (`vc_grant_i`, `vc_grant_id_i`) binds the pending packet, with every flit received so far, to the named channel. That channel's `vc_busy_o` bit rises on the next cycle. A grant to a busy channel is ignored, and so is a grant when no packet is pending.
- R7: A body or tail that arrives after its packet's grant is appended directly to that channel's list. The channel's `vc_ready_o` bit is high while it holds unread flits.
- R8: A read of channel `rd_vc_i` presents the channel's oldest unread flit on `rd_flit_o` and its slot on `rd_slot_o`, with `rd_valid_o` high, in the same cycle. Flits leave in arrival order. A read of a channel with no stored flit has no effect.
- R9: At the clock edge of a valid read, the slot's type bits return to 00 and its `credit_o` bit sets.
- R10: Reading a tail clears the channel's `vc_busy_o` bit on the next cycle, and the channel can then be granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Incoming flit valid |
| in_flit_i | input | FLIT_W | Incoming flit, type in bits [1:0] |
| in_ready_o | output | 1 | Block can take the offered flit |
| hdr_valid_o | output | 1 | Header accepted this cycle |
| hdr_slot_o | output | $clog2(NUM_SLOTS) | Slot receiving the header |
| hdr_flit_o | output | FLIT_W | Header flit for route computation |
| vc_grant_i | input | 1 | Channel grant for the pending packet |
| vc_grant_id_i | input | $clog2(NUM_VC) | Granted channel |
| vc_busy_o | output | NUM_VC | Channel holds a bound packet |
| vc_ready_o | output | NUM_VC | Channel has an unread flit |
| rd_en_i | input | 1 | Read request |
| rd_vc_i | input | $clog2(NUM_VC) | Channel to read |
| rd_valid_o | output | 1 | Read request hits a stored flit |
| rd_slot_o | output | $clog2(NUM_SLOTS) | Slot being read |
| rd_flit_o | output | FLIT_W | Flit being read |
| credit_o | output | NUM_SLOTS | Per-slot free vector sent upstream |

## Verification
A corrupt slot type field shows up on `credit_o` at the next edge. It also changes which slot the next flit takes, so `hdr_slot_o` or a later `rd_slot_o` moves off its expected index within one packet. A wrong table write or read count shows on the next read of that channel: `rd_flit_o` carries a flit out of order or from another packet. A missed tail release leaves `vc_busy_o` set one cycle after the tail is read. A broken pending guard lets `in_ready_o` rise for a second header in the same cycle that the header is offered.

// File: rtl/ubs_pkg.sv
package ubs_pkg;
  typedef enum logic [1:0] {
    FT_EMPTY = 2'b00,
    FT_HEAD  = 2'b01,
    FT_BODY  = 2'b10,
    FT_TAIL  = 2'b11
  } flit_type_e;
endpackage

// File: rtl/ubs_free_pick.sv
module ubs_free_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  free_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |free_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/ubs_slot_store.sv
module ubs_slot_store
  import ubs_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int FLIT_W    = 128,
  parameter int SI_W      = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [SI_W-1:0]      wr_idx_i,
  input  logic [FLIT_W-1:0]    wr_flit_i,
  input  logic                 rd_en_i,
  input  logic [SI_W-1:0]      rd_idx_i,
  output logic [FLIT_W-1:0]    rd_flit_o,
  output logic [NUM_SLOTS-1:0] free_o
);
  logic [1:0]        typ_q [NUM_SLOTS];
  logic [FLIT_W-3:0] pay_q [NUM_SLOTS];

  // type bits double as the occupancy flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SLOTS; i++) typ_q[i] <= FT_EMPTY;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (wr_en_i && wr_idx_i == SI_W'(i))      typ_q[i] <= wr_flit_i[1:0];
        else if (rd_en_i && rd_idx_i == SI_W'(i)) typ_q[i] <= FT_EMPTY;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) pay_q[wr_idx_i] <= wr_flit_i[FLIT_W-1:2];
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_free
    assign free_o[g] = (typ_q[g] == FT_EMPTY);
  end

  assign rd_flit_o = {pay_q[rd_idx_i], typ_q[rd_idx_i]};

  AST_WR_INTO_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> free_o[wr_idx_i]); // R2
  AST_WR_OCCUPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_flit_i[1:0] != FT_EMPTY |=> !free_o[$past(wr_idx_i)]); // R2
  AST_RD_FROM_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> !free_o[rd_idx_i]); // R9
  AST_RD_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !(wr_en_i && wr_idx_i == rd_idx_i) |=> free_o[$past(rd_idx_i)]); // R9
endmodule

// File: rtl/ubs_ctrl_table.sv
module ubs_ctrl_table #(
  parameter int NUM_VC  = 4,
  parameter int PKT_LEN = 4,
  parameter int SI_W    = 4,
  parameter int VC_W    = $clog2(NUM_VC),
  parameter int CNT_W   = $clog2(PKT_LEN + 1),
  parameter int PI_W    = $clog2(PKT_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              app_en_i,
  input  logic              app_hdr_i,
  input  logic              app_tail_i,
  input  logic [SI_W-1:0]   app_slot_i,
  input  logic              grant_en_i,
  input  logic [VC_W-1:0]   grant_vc_i,
  input  logic              rd_en_i,
  input  logic [VC_W-1:0]   rd_vc_i,
  input  logic              rd_tail_i,
  output logic              rd_valid_o,
  output logic [SI_W-1:0]   rd_slot_o,
  output logic [NUM_VC-1:0] vc_busy_o,
  output logic [NUM_VC-1:0] vc_ready_o,
  output logic              pend_valid_o,
  output logic              cur_open_o
);
  logic              pend_val_q, pend_val_n;
  logic [CNT_W-1:0]  pend_cnt_q, pend_cnt_n;
  logic [SI_W-1:0]   pend_slot_q [PKT_LEN];
  logic [SI_W-1:0]   pend_slot_n [PKT_LEN];
  logic              cur_open_q, cur_bound_q;
  logic [VC_W-1:0]   cur_vc_q;
  logic [NUM_VC-1:0] busy_q;
  logic [CNT_W-1:0]  wcnt_q [NUM_VC];
  logic [CNT_W-1:0]  rcnt_q [NUM_VC];
  logic [SI_W-1:0]   vc_slot_q [NUM_VC][PKT_LEN];
  logic              grant_ok, rd_ok, app_bound;

  assign app_bound = app_en_i && !app_hdr_i && cur_open_q && cur_bound_q;
  assign grant_ok  = grant_en_i && pend_val_q && !busy_q[grant_vc_i];
  assign rd_ok     = rd_en_i && busy_q[rd_vc_i] && (rcnt_q[rd_vc_i] != wcnt_q[rd_vc_i]);
  assign rd_valid_o = rd_ok;
  assign rd_slot_o  = vc_slot_q[rd_vc_i][rcnt_q[rd_vc_i][PI_W-1:0]];

  // pending record after this cycle's append, so a grant captures it
  always_comb begin
    pend_val_n = pend_val_q;
    pend_cnt_n = pend_cnt_q;
    for (int k = 0; k < PKT_LEN; k++) pend_slot_n[k] = pend_slot_q[k];
    if (app_en_i && app_hdr_i) begin
      pend_val_n     = 1'b1;
      pend_cnt_n     = CNT_W'(1);
      pend_slot_n[0] = app_slot_i;
    end else if (app_en_i && cur_open_q && !cur_bound_q) begin
      pend_slot_n[pend_cnt_q[PI_W-1:0]] = app_slot_i;
      pend_cnt_n = pend_cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_val_q  <= 1'b0;
      pend_cnt_q  <= '0;
      cur_open_q  <= 1'b0;
      cur_bound_q <= 1'b0;
      cur_vc_q    <= '0;
      busy_q      <= '0;
      for (int k = 0; k < PKT_LEN; k++) pend_slot_q[k] <= '0;
      for (int v = 0; v < NUM_VC; v++) begin
        wcnt_q[v] <= '0;
        rcnt_q[v] <= '0;
        for (int k = 0; k < PKT_LEN; k++) vc_slot_q[v][k] <= '0;
      end
    end else begin
      pend_val_q <= grant_ok ? 1'b0 : pend_val_n;
      pend_cnt_q <= grant_ok ? '0 : pend_cnt_n;
      for (int k = 0; k < PKT_LEN; k++) pend_slot_q[k] <= pend_slot_n[k];

      if (app_en_i && app_hdr_i) begin
        cur_open_q  <= 1'b1;
        cur_bound_q <= 1'b0;
      end else begin
        if (app_en_i && app_tail_i) cur_open_q <= 1'b0;
        if (grant_ok && cur_open_q && !cur_bound_q) begin
          cur_bound_q <= 1'b1;
          cur_vc_q    <= grant_vc_i;
        end
      end

      for (int v = 0; v < NUM_VC; v++) begin
        if (grant_ok && grant_vc_i == VC_W'(v)) begin
          busy_q[v] <= 1'b1;
          wcnt_q[v] <= pend_cnt_n;
          rcnt_q[v] <= '0;
          for (int k = 0; k < PKT_LEN; k++) vc_slot_q[v][k] <= pend_slot_n[k];
        end else begin
          if (app_bound && cur_vc_q == VC_W'(v)) begin
            vc_slot_q[v][wcnt_q[v][PI_W-1:0]] <= app_slot_i;
            wcnt_q[v] <= wcnt_q[v] + CNT_W'(1);
          end
          if (rd_ok && rd_vc_i == VC_W'(v)) begin
            if (rd_tail_i) begin
              busy_q[v] <= 1'b0;
              wcnt_q[v] <= '0;
              rcnt_q[v] <= '0;
            end else begin
              rcnt_q[v] <= rcnt_q[v] + CNT_W'(1);
            end
          end
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
    assign vc_ready_o[g] = busy_q[g] && (rcnt_q[g] != wcnt_q[g]);
    AST_LIST_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wcnt_q[g] <= CNT_W'(PKT_LEN)); // R7
  end

  assign vc_busy_o    = busy_q;
  assign pend_valid_o = pend_val_q;
  assign cur_open_o   = cur_open_q;

  AST_GRANT_BINDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_ok |=> busy_q[$past(grant_vc_i)]); // R6
  AST_BUSY_GRANT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_en_i && busy_q[grant_vc_i] && !(rd_ok && rd_vc_i == grant_vc_i)
      |=> $stable(wcnt_q[$past(grant_vc_i)]) || $past(app_bound)); // R6
  AST_TAIL_FREES_VC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok && rd_tail_i |=> !busy_q[$past(rd_vc_i)]); // R10
endmodule

// File: rtl/ubs_slot_mgr.sv
module ubs_slot_mgr
  import ubs_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int FLIT_W    = 128,
  parameter int NUM_VC    = 4,
  parameter int PKT_LEN   = 4,
  localparam int SI_W     = $clog2(NUM_SLOTS),
  localparam int VC_W     = $clog2(NUM_VC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic [FLIT_W-1:0]    in_flit_i,
  output logic                 in_ready_o,
  output logic                 hdr_valid_o,
  output logic [SI_W-1:0]      hdr_slot_o,
  output logic [FLIT_W-1:0]    hdr_flit_o,
  input  logic                 vc_grant_i,
  input  logic [VC_W-1:0]      vc_grant_id_i,
  output logic [NUM_VC-1:0]    vc_busy_o,
  output logic [NUM_VC-1:0]    vc_ready_o,
  input  logic                 rd_en_i,
  input  logic [VC_W-1:0]      rd_vc_i,
  output logic                 rd_valid_o,
  output logic [SI_W-1:0]      rd_slot_o,
  output logic [FLIT_W-1:0]    rd_flit_o,
  output logic [NUM_SLOTS-1:0] credit_o
);
  logic [NUM_SLOTS-1:0] free_vec;
  logic                 free_found;
  logic [SI_W-1:0]      free_idx;
  logic                 pend_valid, cur_open;
  logic                 is_hdr, is_bt, is_tail, accept, store_en;
  logic [SI_W-1:0]      rd_slot;
  logic                 rd_valid;
  logic [FLIT_W-1:0]    rd_flit;

  assign is_hdr  = in_flit_i[1:0] == FT_HEAD;
  assign is_tail = in_flit_i[1:0] == FT_TAIL;
  assign is_bt   = is_tail || in_flit_i[1:0] == FT_BODY;

  // one packet at a time may wait for a channel
  assign in_ready_o = free_found && !(is_hdr && pend_valid);
  assign accept     = in_valid_i && in_ready_o;
  assign store_en   = accept && (is_hdr || (is_bt && cur_open));

  assign hdr_valid_o = accept && is_hdr;
  assign hdr_slot_o  = free_idx;
  assign hdr_flit_o  = in_flit_i;

  ubs_free_pick #(.N(NUM_SLOTS), .IW(SI_W)) u_pick (
    .free_i  (free_vec),
    .found_o (free_found),
    .idx_o   (free_idx)
  );

  ubs_slot_store #(.NUM_SLOTS(NUM_SLOTS), .FLIT_W(FLIT_W), .SI_W(SI_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (store_en),
    .wr_idx_i  (free_idx),
    .wr_flit_i (in_flit_i),
    .rd_en_i   (rd_valid),
    .rd_idx_i  (rd_slot),
    .rd_flit_o (rd_flit),
    .free_o    (free_vec)
  );

  ubs_ctrl_table #(.NUM_VC(NUM_VC), .PKT_LEN(PKT_LEN), .SI_W(SI_W)) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .app_en_i     (store_en),
    .app_hdr_i    (is_hdr),
    .app_tail_i   (is_tail),
    .app_slot_i   (free_idx),
    .grant_en_i   (vc_grant_i),
    .grant_vc_i   (vc_grant_id_i),
    .rd_en_i      (rd_en_i),
    .rd_vc_i      (rd_vc_i),
    .rd_tail_i    (rd_flit[1:0] == FT_TAIL),
    .rd_valid_o   (rd_valid),
    .rd_slot_o    (rd_slot),
    .vc_busy_o    (vc_busy_o),
    .vc_ready_o   (vc_ready_o),
    .pend_valid_o (pend_valid),
    .cur_open_o   (cur_open)
  );

  assign rd_valid_o = rd_valid;
  assign rd_slot_o  = rd_slot;
  assign rd_flit_o  = rd_flit;
  assign credit_o   = free_vec;

  AST_READY_NEEDS_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> |credit_o); // R5
  AST_HDR_SLOT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> credit_o[hdr_slot_o]); // R3
  AST_DISCARD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !store_en && !rd_valid |=> $stable(credit_o)); // R4
endmodule

// File: tb/ubs_slot_mgr_tb.sv
module ubs_slot_mgr_tb;
  localparam int NUM_SLOTS = 16;
  localparam int FLIT_W    = 128;
  localparam int NUM_VC    = 4;
  localparam int PKT_LEN   = 4;

  // {type[1:0], tag[7:0], slot[3:0], header}
  localparam logic [14:0] VEC [5] = '{
    {2'b01, 8'h10, 4'd0, 1'b1},
    {2'b10, 8'h11, 4'd1, 1'b0},
    {2'b00, 8'h1F, 4'd0, 1'b0},
    {2'b10, 8'h12, 4'd2, 1'b0},
    {2'b11, 8'h13, 4'd3, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic              in_valid_i = 1'b0;
  logic [FLIT_W-1:0] in_flit_i = '0;
  logic              in_ready_o, hdr_valid_o;
  logic [3:0]        hdr_slot_o;
  logic [FLIT_W-1:0] hdr_flit_o;
  logic              vc_grant_i = 1'b0;
  logic [1:0]        vc_grant_id_i = '0;
  logic [3:0]        vc_busy_o, vc_ready_o;
  logic              rd_en_i = 1'b0;
  logic [1:0]        rd_vc_i = '0;
  logic              rd_valid_o;
  logic [3:0]        rd_slot_o;
  logic [FLIT_W-1:0] rd_flit_o;
  logic [15:0]       credit_o;

  ubs_slot_mgr #(.NUM_SLOTS(NUM_SLOTS), .FLIT_W(FLIT_W), .NUM_VC(NUM_VC), .PKT_LEN(PKT_LEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_flit_i(in_flit_i), .in_ready_o(in_ready_o),
    .hdr_valid_o(hdr_valid_o), .hdr_slot_o(hdr_slot_o), .hdr_flit_o(hdr_flit_o),
    .vc_grant_i(vc_grant_i), .vc_grant_id_i(vc_grant_id_i),
    .vc_busy_o(vc_busy_o), .vc_ready_o(vc_ready_o),
    .rd_en_i(rd_en_i), .rd_vc_i(rd_vc_i), .rd_valid_o(rd_valid_o),
    .rd_slot_o(rd_slot_o), .rd_flit_o(rd_flit_o), .credit_o(credit_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_free = 16'hFFFF;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input logic [1:0] t, input logic [7:0] tag);
    return {118'd0, tag, t};
  endfunction

  function automatic int lowfree();
    for (int i = 0; i < 16; i++) if (exp_free[i]) return i;
    return 0;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [1:0] t, input logic [7:0] tag);
    int s;
    s = lowfree();
    in_valid_i = 1'b1;
    in_flit_i  = mk(t, tag);
    #1;
    chk(in_ready_o === 1'b1, "R5 ready with free slot", in_ready_o, 1);
    if (t == 2'b01) begin
      chk(hdr_valid_o === 1'b1 && hdr_slot_o == 4'(s), "R3 header slot", hdr_slot_o, s);
      chk(hdr_flit_o == mk(t, tag), "R3 header flit", hdr_flit_o, mk(t, tag));
    end else begin
      chk(hdr_valid_o === 1'b0, "R3 no header strobe", hdr_valid_o, 0);
    end
    tick();
    in_valid_i = 1'b0;
    exp_free[s] = 1'b0;
    chk(credit_o == exp_free, "R2 lowest free slot taken", credit_o, exp_free);
  endtask

  task automatic rd(input logic [1:0] vc, input int slot, input logic [1:0] t, input logic [7:0] tag);
    rd_en_i = 1'b1;
    rd_vc_i = vc;
    #1;
    chk(rd_valid_o === 1'b1 && rd_slot_o == 4'(slot), "R8 read slot order", rd_slot_o, slot);
    chk(rd_flit_o == mk(t, tag), "R8 read flit", rd_flit_o, mk(t, tag));
    tick();
    rd_en_i = 1'b0;
    exp_free[slot] = 1'b1;
    chk(credit_o == exp_free, "R9 slot released", credit_o, exp_free);
  endtask

  task automatic grant(input logic [1:0] vc);
    vc_grant_i    = 1'b1;
    vc_grant_id_i = vc;
    tick();
    vc_grant_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #9;
    chk(credit_o == 16'hFFFF, "R1 reset credit", credit_o, 16'hFFFF);
    chk(in_ready_o === 1'b1, "R1 reset ready", in_ready_o, 1);
    chk(vc_busy_o == 4'b0, "R1 reset busy", vc_busy_o, 0);
    rst_ni = 1'b1;
    tick();

    // table-driven packet with an interleaved empty flit
    for (int k = 0; k < 5; k++) begin
      in_valid_i = 1'b1;
      in_flit_i  = mk(VEC[k][14:13], VEC[k][12:5]);
      #1;
      chk(in_ready_o === 1'b1, "R5 ready", in_ready_o, 1);
      chk(hdr_valid_o === VEC[k][0], "R3 header strobe", hdr_valid_o, VEC[k][0]);
      if (VEC[k][0]) chk(hdr_slot_o == VEC[k][4:1], "R3 header slot", hdr_slot_o, VEC[k][4:1]);
      tick();
      in_valid_i = 1'b0;
      if (VEC[k][14:13] != 2'b00) exp_free[VEC[k][4:1]] = 1'b0;
      chk(credit_o == exp_free, "R2 R4 credit after vector", credit_o, exp_free);
    end
    chk(vc_busy_o == 4'b0 && vc_ready_o == 4'b0, "R6 unbound before grant", vc_busy_o, 0);

    // second header while the first waits for a grant
    in_valid_i = 1'b1;
    in_flit_i  = mk(2'b01, 8'h99);
    #1;
    chk(in_ready_o === 1'b0, "R5 header blocked while pending", in_ready_o, 0);
    in_valid_i = 1'b0;
    tick();
    chk(credit_o == exp_free, "R5 blocked header not stored", credit_o, exp_free);

    // read of empty channel
    rd_en_i = 1'b1;
    rd_vc_i = 2'd0;
    #1;
    chk(rd_valid_o === 1'b0, "R8 empty channel read", rd_valid_o, 0);
    tick();
    rd_en_i = 1'b0;
    chk(credit_o == exp_free, "R8 empty read no effect", credit_o, exp_free);

    grant(2'd2);
    chk(vc_busy_o == 4'b0100 && vc_ready_o == 4'b0100, "R6 grant binds", vc_busy_o, 4'b0100);
    grant(2'd2);
    grant(2'd1);
    chk(vc_busy_o == 4'b0100, "R6 grant ignored", vc_busy_o, 4'b0100);

    send(2'b01, 8'h20);
    grant(2'd0);
    chk(vc_busy_o == 4'b0101, "R6 second grant", vc_busy_o, 4'b0101);
    send(2'b10, 8'h21);
    chk(vc_ready_o[0] === 1'b1, "R7 direct append", vc_ready_o, 4'b0101);

    // write and read in one cycle: freed slot 0 not reused yet
    in_valid_i = 1'b1;
    in_flit_i  = mk(2'b10, 8'h22);
    rd_en_i    = 1'b1;
    rd_vc_i    = 2'd2;
    #1;
    chk(rd_slot_o == 4'd0 && rd_flit_o == mk(2'b01, 8'h10), "R8 first out", rd_slot_o, 0);
    tick();
    in_valid_i = 1'b0;
    rd_en_i    = 1'b0;
    chk(credit_o == 16'hFF81, "R2 R9 same-cycle write and read", credit_o, 16'hFF81);
    exp_free = 16'hFF81;

    rd(2'd2, 1, 2'b10, 8'h11);
    rd(2'd2, 2, 2'b10, 8'h12);
    rd(2'd2, 3, 2'b11, 8'h13);
    chk(vc_busy_o == 4'b0001, "R10 tail frees channel", vc_busy_o, 4'b0001);

    send(2'b11, 8'h23);
    chk(hdr_valid_o === 1'b0 && credit_o == 16'hFF8E, "R2 tail reuses slot 0", credit_o, 16'hFF8E);
    rd(2'd0, 4, 2'b01, 8'h20);
    rd(2'd0, 5, 2'b10, 8'h21);
    rd(2'd0, 6, 2'b10, 8'h22);
    rd(2'd0, 0, 2'b11, 8'h23);
    chk(vc_busy_o == 4'b0 && credit_o == 16'hFFFF, "R10 all released", credit_o, 16'hFFFF);

    // regrant of a released channel
    send(2'b01, 8'h30);
    grant(2'd2);
    chk(vc_busy_o == 4'b0100, "R10 channel regranted", vc_busy_o, 4'b0100);
    send(2'b11, 8'h31);

    // orphan body discarded
    in_valid_i = 1'b1;
    in_flit_i  = mk(2'b10, 8'h32);
    tick();
    in_valid_i = 1'b0;
    chk(credit_o == exp_free, "R4 orphan body discarded", credit_o, exp_free);

    // fill the pool
    for (int p = 0; p < 3; p++) begin
      logic [1:0] vc;
      vc = (p == 2) ? 2'd3 : 2'(p);
      send(2'b01, 8'(8'h40 + 4 * p));
      grant(vc);
      send(2'b10, 8'(8'h41 + 4 * p));
      send(2'b10, 8'(8'h42 + 4 * p));
      send(2'b11, 8'(8'h43 + 4 * p));
    end
    send(2'b01, 8'h70);
    send(2'b10, 8'h71);
    chk(credit_o == 16'h0000, "R5 pool full", credit_o, 0);
    in_valid_i = 1'b1;
    in_flit_i  = mk(2'b10, 8'h72);
    #1;
    chk(in_ready_o === 1'b0, "R5 ready low when full", in_ready_o, 0);
    in_valid_i = 1'b0;
    tick();
    rd(2'd2, 0, 2'b01, 8'h30);
    in_valid_i = 1'b1;
    #1;
    chk(in_ready_o === 1'b1, "R5 ready after release", in_ready_o, 1);
    in_valid_i = 1'b0;
    tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule